// File: doc/BRIEF.md
# Dual-Modulus Fractional-N Feedback Divider

This block is the feedback divider of a fractional-N frequency synthesizer. It runs on the oscillator-side input clock and emits a one-cycle pulse each time a division is complete. Each division is built from a divide-by-4/5 prescaler. A pair of period counters makes the prescaler divide by 5 for a number of its periods and by 4 for the rest. The total is N = 4·N1 + N0, where N1 is the number of prescaler periods and N0 is the number of wide periods.

A first-order sigma-delta accumulator with a programmable modulus moves each division between two integers. The average ratio is then N + FRAC/MOD. The integer ratio, the fraction and the modulus are sampled only on the last input cycle of a division, which is called the boundary. The fraction is added to the accumulator at each boundary. A carry out of the modulus makes the next division one longer.

The sequencing is done by a state machine with three states. ST_IDLE is the single cycle after reset in which the first configuration is taken. ST_WIDE means the prescaler divides by 5, and ST_NARROW means it divides by 4. The transitions are named as follows:
- start: ST_IDLE goes to ST_WIDE, or to ST_NARROW when N0 is 0.
- swallow-done: ST_WIDE goes to ST_NARROW when the last wide period ends.
- wrap: the last period of a division ends, and the machine goes back to ST_WIDE or ST_NARROW according to the next division value.

Top module: `fnd_divider`

## Requirements
- R1: While reset is asserted, `div_pulse` and `pre_tick` are 0.
- R2: With `frac` = 0, every division lasts exactly `n_div` input cycles.
- R3: Within a division of D cycles, with D = 4·N1 + N0 and N0 = D mod 4, `pre_tick` fires N1 times. The first N0 gaps between ticks are 5 cycles and the remaining gaps are 4 cycles, counted from the start of the division. The last tick coincides with `div_pulse`.
- R4: At each boundary the accumulator computes s = acc + `frac`. When s ≥ `modulus`, the next division is `n_div`+1 and acc becomes s−`modulus`. Otherwise the next division is `n_div` and acc becomes s.
- R5: Over `modulus` consecutive divisions that start with a cleared accumulator and a constant configuration, the input cycles total exactly `n_div`·`modulus` + `frac`.
- R6: A change of `n_div`, `frac` or `modulus` in the middle of a division does not alter that division. The change takes effect from the next division.
- R7: When `frac` or `modulus` at a boundary differs from the value taken at the previous boundary, the accumulator restarts from 0 before the addition.
- R8: `n_div` from 16 to 47 is supported, including the carried value 48. With `frac` < `modulus` and `modulus` ≠ 0, the divisions at both ends of this range are exact.
- R9: The first division after reset uses the configuration present in the first cycle after release, with the accumulator at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input (oscillator-side) clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| n_div | input | N_W | Integer division ratio, 16..47 |
| frac | input | MOD_W | Fraction numerator, less than modulus |
| modulus | input | MOD_W | Fraction modulus, nonzero |
| div_pulse | output | 1 | One-cycle pulse on the last input cycle of each division |
| pre_tick | output | 1 | One-cycle pulse on the last input cycle of each prescaler period |

## Verification
The hardest case to reach from the ports is an accumulator restart that changes a division length. A restart can only be seen when the residue it discards would have produced a carry that the fresh sum does not produce. A directed sequence first builds a residue of 1 with FRAC=2 and MOD=3, then switches to FRAC=3 and MOD=4. A carried division there would show that the restart was skipped. Random segments then change the configuration at boundaries and in the middle of divisions, and each one runs for a whole modulus window so that the exact total can be checked.

// File: rtl/fnd_pkg.sv
package fnd_pkg;

    // Sequencer states
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WIDE   = 2'd1,
        ST_NARROW = 2'd2
    } fnd_state_e;

    // log2 of the low prescaler modulus (4)
    localparam int PRE_LOG = 2;

endpackage

// File: rtl/fnd_prescaler.sv
module fnd_prescaler #(
    parameter int PRE_LOG = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    input  logic wide,
    output logic tick
);
    localparam int CNT_W = PRE_LOG + 1;
    localparam logic [CNT_W-1:0] LAST_LO = CNT_W'((1 << PRE_LOG) - 1);
    localparam logic [CNT_W-1:0] LAST_HI = CNT_W'(1 << PRE_LOG);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_v;

    always_comb begin
        last_v = wide ? LAST_HI : LAST_LO;
        tick   = run && (cnt_q == last_v);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart || tick) begin
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/fnd_frac_acc.sv
module fnd_frac_acc #(
    parameter int N_W   = 6,
    parameter int MOD_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [N_W-1:0]   n_in,
    input  logic [MOD_W-1:0] frac_in,
    input  logic [MOD_W-1:0] mod_in,
    output logic [N_W:0]     next_div
);
    localparam int DIV_W = N_W + 1;

    logic [MOD_W-1:0] acc_q, frac_q, mod_q;
    logic [MOD_W-1:0] acc_base;
    logic [MOD_W:0]   sum_v;
    logic             carry;
    logic [MOD_W-1:0] acc_d;

    always_comb begin
        acc_base = ((frac_in != frac_q) || (mod_in != mod_q)) ? '0 : acc_q;
        sum_v    = {1'b0, acc_base} + {1'b0, frac_in};
        carry    = (sum_v >= {1'b0, mod_in});
        acc_d    = carry ? MOD_W'(sum_v - {1'b0, mod_in}) : sum_v[MOD_W-1:0];
        next_div = {1'b0, n_in} + DIV_W'(carry);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q  <= '0;
            frac_q <= '0;
            mod_q  <= '0;
        end else if (load) begin
            acc_q  <= acc_d;
            frac_q <= frac_in;
            mod_q  <= mod_in;
        end
    end
endmodule

// File: rtl/fnd_swallow_fsm.sv
module fnd_swallow_fsm
    import fnd_pkg::*;
#(
    parameter int DIV_W   = 7,
    parameter int PRE_LOG = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [DIV_W-1:0] next_div,
    output logic             run,
    output logic             wide,
    output logic             load,
    output logic             pulse
);
    localparam int PER_W = DIV_W - PRE_LOG;

    fnd_state_e          state_q, state_d;
    logic [PER_W-1:0]    periods_q, periods_d;
    logic [PRE_LOG-1:0]  swallow_q, swallow_d;
    logic                last_period;

    // Next-state and counter logic
    always_comb begin
        state_d   = state_q;
        periods_d = periods_q;
        swallow_d = swallow_q;
        if (load) begin
            periods_d = next_div[DIV_W-1:PRE_LOG];
            swallow_d = next_div[PRE_LOG-1:0];
            state_d   = (|next_div[PRE_LOG-1:0]) ? ST_WIDE : ST_NARROW;
        end else if (tick) begin
            periods_d = periods_q - PER_W'(1);
            unique case (state_q)
                ST_WIDE: begin
                    swallow_d = swallow_q - PRE_LOG'(1);
                    if (swallow_q == PRE_LOG'(1)) state_d = ST_NARROW;
                end
                ST_NARROW: state_d = ST_NARROW;
                ST_IDLE:   state_d = ST_IDLE;
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            periods_q <= '0;
            swallow_q <= '0;
        end else begin
            state_q   <= state_d;
            periods_q <= periods_d;
            swallow_q <= swallow_d;
        end
    end

    // Outputs
    always_comb begin
        last_period = (periods_q == PER_W'(1));
        run   = 1'b0;
        wide  = 1'b0;
        pulse = 1'b0;
        load  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                load = 1'b1;
            end
            ST_WIDE: begin
                run   = 1'b1;
                wide  = 1'b1;
                pulse = tick && last_period;
                load  = tick && last_period;
            end
            ST_NARROW: begin
                run   = 1'b1;
                pulse = tick && last_period;
                load  = tick && last_period;
            end
            default: load = 1'b1;
        endcase
    end
endmodule

// File: rtl/fnd_divider.sv
module fnd_divider #(
    parameter int N_W   = 6,
    parameter int MOD_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_W-1:0]   n_div,
    input  logic [MOD_W-1:0] frac,
    input  logic [MOD_W-1:0] modulus,
    output logic             div_pulse,
    output logic             pre_tick
);
    localparam int DIV_W = N_W + 1;
    localparam int P_LOG = fnd_pkg::PRE_LOG;

    logic             run, wide, load, tick, pulse;
    logic [DIV_W-1:0] next_div;

    fnd_frac_acc #(.N_W(N_W), .MOD_W(MOD_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .load(load),
        .n_in(n_div), .frac_in(frac), .mod_in(modulus),
        .next_div(next_div)
    );

    fnd_prescaler #(.PRE_LOG(P_LOG)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(run), .restart(load),
        .wide(wide), .tick(tick)
    );

    fnd_swallow_fsm #(.DIV_W(DIV_W), .PRE_LOG(P_LOG)) u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(tick), .next_div(next_div),
        .run(run), .wide(wide), .load(load), .pulse(pulse)
    );

    assign div_pulse = pulse;
    assign pre_tick  = tick;
endmodule

// File: rtl/fnd_divider_chk.sv
module fnd_divider_chk #(
    parameter int N_W     = 6,
    parameter int MOD_W   = 12,
    parameter int PRE_LOG = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_W-1:0]   n_div,
    input logic [MOD_W-1:0] frac,
    input logic             div_pulse,
    input logic             pre_tick
);
    localparam int G_W = N_W + 2;
    localparam logic [G_W-1:0] P_LO = G_W'(1 << PRE_LOG);
    localparam logic [G_W-1:0] P_HI = G_W'((1 << PRE_LOG) + 1);

    logic           started;
    logic [G_W-1:0] gap, tgap, n_seen;
    logic           f_zero;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            started <= 1'b0;
            gap     <= '0;
            tgap    <= '0;
            n_seen  <= '0;
            f_zero  <= 1'b0;
        end else begin
            started <= 1'b1;
            if (!started || div_pulse) begin
                gap    <= G_W'(1);
                n_seen <= G_W'(n_div);
                f_zero <= (frac == '0);
            end else begin
                gap <= gap + G_W'(1);
            end
            if (!started || pre_tick) tgap <= G_W'(1);
            else                      tgap <= tgap + G_W'(1);
        end
    end

    // R1
    a_r1_quiet_in_reset: assert property (@(posedge clk)
        !rst_n |-> (!div_pulse && !pre_tick));

    // R3
    a_r3_pulse_ends_period: assert property (@(posedge clk) disable iff (!rst_n)
        div_pulse |-> pre_tick);

    // R3
    a_r3_period_len: assert property (@(posedge clk) disable iff (!rst_n)
        (started && pre_tick) |-> (tgap == P_LO || tgap == P_HI));

    // R4
    a_r4_div_choice: assert property (@(posedge clk) disable iff (!rst_n)
        (started && div_pulse) |-> (gap == n_seen || gap == n_seen + G_W'(1)));

    // R2
    a_r2_integer_exact: assert property (@(posedge clk) disable iff (!rst_n)
        (started && div_pulse && f_zero) |-> (gap == n_seen));

    // R9
    a_r9_idle_first: assert property (@(posedge clk) disable iff (!rst_n)
        !started |-> (!pre_tick && !div_pulse));
endmodule

bind fnd_divider fnd_divider_chk #(.N_W(N_W), .MOD_W(MOD_W), .PRE_LOG(fnd_pkg::PRE_LOG)) u_chk (
    .clk(clk), .rst_n(rst_n), .n_div(n_div), .frac(frac),
    .div_pulse(div_pulse), .pre_tick(pre_tick)
);

// File: tb/fnd_divider_bench.sv
`timescale 1ns/1ps
module fnd_divider_bench;
    localparam int N_W   = 6;
    localparam int MOD_W = 12;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [N_W-1:0]   n_div = 6'd20;
    logic [MOD_W-1:0] frac = '0;
    logic [MOD_W-1:0] modulus = 12'd1;
    logic             div_pulse, pre_tick;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int m_acc = 0, m_frac = 0, m_mod = 0;

    always #2.5 clk = ~clk;

    fnd_divider #(.N_W(N_W), .MOD_W(MOD_W)) u_fnd_divider (
        .clk(clk), .rst_n(rst_n), .n_div(n_div), .frac(frac),
        .modulus(modulus), .div_pulse(div_pulse), .pre_tick(pre_tick)
    );

    // Expected next division from the accumulator rule (R4, R7)
    function automatic int model_next(input int n, input int f, input int m);
        int base, s;
        base = ((f != m_frac) || (m != m_mod)) ? 0 : m_acc;
        s = base + f;
        m_frac = f;
        m_mod  = m;
        if (s >= m) begin
            m_acc = s - m;
            return n + 1;
        end
        m_acc = s;
        return n;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_cfg(input int n, input int f, input int m);
        n_div = N_W'(n);
        frac = MOD_W'(f);
        modulus = MOD_W'(m);
    endtask

    // Waits for the next div_pulse and checks its length and the tick pattern (R3).
    // When chg_at > 0, the configuration is changed in the middle of the division.
    task automatic run_div(input int exp, input string req, output int got,
                           input int chg_at, input int cn, input int cf, input int cm);
        int cnt, last_t, nt, n0;
        bit pat_ok;
        cnt = 0; last_t = 0; nt = 0; pat_ok = 1'b1;
        n0 = exp % 4;
        do begin
            @(negedge clk);
            cnt++;
            if (chg_at > 0 && cnt == chg_at) set_cfg(cn, cf, cm);
            if (pre_tick) begin
                if ((cnt - last_t) != ((nt < n0) ? 5 : 4)) pat_ok = 1'b0;
                last_t = cnt;
                nt++;
            end
        end while (!div_pulse && cnt < 200);
        got = cnt;
        check(cnt == exp, req, cnt, exp);
        check(pat_ok && nt == exp / 4, "R3", nt, exp / 4);
    endtask

    task automatic do_reset(input int n, input int f, input int m);
        rst_n = 1'b0;
        set_cfg(n, f, m);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(!div_pulse && !pre_tick, "R1", int'(div_pulse) + int'(pre_tick), 0);
        end
        m_acc = 0; m_frac = 0; m_mod = 0;
        rst_n = 1'b1;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int got, e, tot, n, f, m;
        void'($urandom(32'd7741));

        // R1, R9: reset, then the first division uses the held configuration
        do_reset(20, 0, 1);
        e = model_next(20, 0, 1);
        run_div(e, "R9", got, 0, 0, 0, 0);

        // R2: integer division at several ratios
        for (int i = 0; i < 3; i++) begin
            e = model_next(20, 0, 1);
            run_div(e, "R2", got, 0, 0, 0, 0);
        end
        set_cfg(23, 0, 1); e = model_next(23, 0, 1); run_div(e, "R2", got, 0, 0, 0, 0);

        // R8: ends of the range
        set_cfg(16, 0, 1); e = model_next(16, 0, 1); run_div(e, "R8", got, 0, 0, 0, 0);
        set_cfg(47, 0, 1); e = model_next(47, 0, 1); run_div(e, "R8", got, 0, 0, 0, 0);
        set_cfg(47, 5, 6);
        tot = 0;
        for (int i = 0; i < 6; i++) begin
            e = model_next(47, 5, 6); run_div(e, "R8", got, 0, 0, 0, 0); tot += got;
        end
        check(tot == 47 * 6 + 5, "R8", tot, 47 * 6 + 5);

        // R4, R5: fractional sequence over a full window
        set_cfg(30, 3, 7);
        tot = 0;
        for (int i = 0; i < 7; i++) begin
            e = model_next(30, 3, 7); run_div(e, "R4", got, 0, 0, 0, 0); tot += got;
        end
        check(tot == 30 * 7 + 3, "R5", tot, 30 * 7 + 3);

        // R7: a restart drops the residue (2/3 twice leaves 1, then 3/4 gives no carry)
        set_cfg(20, 2, 3);
        e = model_next(20, 2, 3); run_div(e, "R4", got, 0, 0, 0, 0);
        e = model_next(20, 2, 3); run_div(e, "R4", got, 0, 0, 0, 0);
        check(got == 21, "R4", got, 21);
        set_cfg(20, 3, 4);
        e = model_next(20, 3, 4); run_div(e, "R7", got, 0, 0, 0, 0);
        check(got == 20, "R7", got, 20);

        // R6: a mid-division change leaves the current division unchanged
        set_cfg(40, 0, 1); e = model_next(40, 0, 1);
        run_div(e, "R6", got, 7, 17, 0, 1);
        e = model_next(17, 0, 1); run_div(e, "R6", got, 0, 0, 0, 0);

        // R9: a reset in the middle of a division restarts with the accumulator at 0
        do_reset(33, 5, 6);
        e = model_next(33, 5, 6); run_div(e, "R9", got, 0, 0, 0, 0);
        check(got == 33, "R9", got, 33);

        // Random segments: each one runs a full window, some with mid-division changes
        for (int s = 0; s < 40; s++) begin
            n = 16 + int'($urandom_range(31, 0));
            m = 1 + int'($urandom_range(8, 0));
            f = int'($urandom_range(m - 1, 0));
            if (n == 47 && f == 0) f = 0;
            set_cfg(n, f, m);
            tot = 0;
            for (int i = 0; i < m; i++) begin
                e = model_next(n, f, m);
                run_div(e, "R4", got, 0, 0, 0, 0);
                tot += got;
            end
            check(tot == n * m + f, "R5", tot, n * m + f);
            if (s % 5 == 0) begin
                e = model_next(n, f, m);
                run_div(e, "R6", got, 3, 16 + (s % 20), 0, 1);
                e = model_next(16 + (s % 20), 0, 1);
                run_div(e, "R2", got, 0, 0, 0, 0);
            end
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule